// File: doc/BRIEF.md
# Three-Channel Asymmetric Decode Steering

This block sits between an instruction queue whose entries already have their boundaries marked and a set of parallel decode channels. Each cycle it looks at a window of up to three queue entries. For every entry it receives a valid bit, the number of micro-ops the instruction expands to, and its length in bytes. From these it forms a decode group that keeps program order. Channel 0 is the wide channel: it accepts any instruction whose expansion fits in four micro-ops. The other channels accept only short single-micro-op instructions. An instruction that expands beyond four micro-ops is handed to the microcode sequencer and is issued on its own.

The block drives a combinational consume count back to the queue, so the queue knows how far to advance. The chosen group is registered onto the channel outputs at the next clock edge. A downstream stall freezes those outputs. A flush clears them and also drops any outstanding wait on the microcode sequencer. The channel count, the field widths, the wide-channel micro-op limit and the full-rate length limit are all parameters.

Top module: `dsteer_top`

## Requirements
- R1: After reset every channel output is empty: all valid bits, micro-op fields and length fields are 0. The consume count is 0 and the sequencer busy flag is low.
- R2: Window entry 0, when valid and needing at most 4 micro-ops, is taken on channel 0. Each following entry that needs exactly 1 micro-op and is at most 7 bytes long is taken on the next channel. The consume count equals the number of entries taken.
- R3: An entry in slot 1 or higher that needs 2 or more micro-ops is not taken, and the group ends before it. It waits to become entry 0 in a later cycle.
- R4: An entry longer than 7 bytes is taken only on channel 0, and the group closes after it. In slot 1 or higher such an entry is not taken.
- R5: An entry 0 that needs more than 4 micro-ops is issued alone on channel 0, and the busy flag rises at the same edge. While busy is high the consume count is 0 and no new group is issued. A done pulse clears busy at the next edge.
- R6: Assignment is strictly in order. An invalid entry ends the group, and no later valid entry is taken past it.
- R7: While stall is high the channel outputs hold their values and the consume count is 0.
- R8: While flush is high the consume count is 0. At the next edge all channel outputs are cleared and busy is cleared.
- R9: A group chosen in one cycle appears on the channel outputs after the next rising edge. Channel k carries the micro-op count and length of window entry k. Lanes that were not taken read valid 0 with zero fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_vld | input | NUM_CH | Valid bit per window entry, entry 0 oldest |
| win_uops | input | NUM_CH*UOP_W | Micro-op count per entry, entry k at bits k*UOP_W upward |
| win_len | input | NUM_CH*LEN_W | Byte length per entry, entry k at bits k*LEN_W upward |
| stall_i | input | 1 | Downstream stall, holds the current assignment |
| flush_i | input | 1 | Drops the pending group and the sequencer wait |
| ucode_done_i | input | 1 | Sequencer has finished the long instruction |
| take_cnt | output | $clog2(NUM_CH+1) | Entries consumed this cycle |
| ch_vld | output | NUM_CH | Channel holds an instruction |
| ch_uops | output | NUM_CH*UOP_W | Micro-op count per channel |
| ch_len | output | NUM_CH*LEN_W | Length per channel |
| ucode_busy_o | output | 1 | Waiting on the microcode sequencer |

## Verification
Some properties are checked by the assertions on every cycle. The side channels only ever hold short single-micro-op instructions. The occupied lanes always form a prefix. A long-expansion instruction never shares its cycle with another. Busy forces a zero consume count. A stall freezes the outputs, and a flush empties them and drops busy. The number of lanes loaded matches the count reported the cycle before.

The exact grouping decision can only be shown by the bench scenarios. Those scenarios sweep every combination of seven entry classes across the three slots, including the 7-byte and 8-byte length boundary and the 4-micro-op and 5-micro-op boundary. They also cover the full sequencer handshake, and stall and flush arriving on top of a loaded group.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;

   // Capability class of one window entry
   typedef enum logic [1:0] {
      KIND_NONE   = 2'd0,  // empty slot
      KIND_SIMPLE = 2'd1,  // fits any channel
      KIND_WIDE   = 2'd2,  // needs channel 0, fits its limit
      KIND_SOLO   = 2'd3   // needs the microcode sequencer
   } slot_kind_e;

   typedef struct packed {
      slot_kind_e kind;
      logic       closes;  // group may not grow past this entry
   } slot_info_t;

endpackage

// File: rtl/dsteer_classify.sv
module dsteer_classify
   import dsteer_pkg::*;
#(
   parameter int UOP_W      = 4,
   parameter int LEN_W      = 4,
   parameter int WIDE_UOPS  = 4,
   parameter int FAST_LEN   = 7
) (
   input  logic             vld,
   input  logic [UOP_W-1:0] uops,
   input  logic [LEN_W-1:0] len,
   output slot_info_t       info
);

   localparam logic [UOP_W-1:0] WIDE_LIM = UOP_W'(WIDE_UOPS);
   localparam logic [LEN_W-1:0] FAST_LIM = LEN_W'(FAST_LEN);

   logic is_long;
   logic is_multi;
   logic is_solo;

   always_comb begin
      is_long  = (len > FAST_LIM);
      is_multi = (uops > UOP_W'(1));
      is_solo  = (uops > WIDE_LIM);
      info.closes = 1'b0;
      if (!vld) begin
         info.kind = KIND_NONE;
      end else if (is_solo) begin
         info.kind   = KIND_SOLO;
         info.closes = 1'b1;
      end else if (is_multi || is_long) begin
         info.kind   = KIND_WIDE;
         info.closes = is_long;
      end else begin
         info.kind = KIND_SIMPLE;
      end
   end

endmodule

// File: rtl/dsteer_grouper.sv
module dsteer_grouper
   import dsteer_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 2
) (
   input  logic                    open_i,
   input  slot_info_t [NUM_CH-1:0] info,
   output logic [NUM_CH-1:0]       take,
   output logic [CNT_W-1:0]        cnt,
   output logic                    solo
);

   logic [NUM_CH-1:0] cont;   // group may extend beyond slot k

   assign take[0] = open_i && (info[0].kind != KIND_NONE);
   assign cont[0] = take[0] && !info[0].closes;
   assign solo    = take[0] && (info[0].kind == KIND_SOLO);

   for (genvar k = 1; k < NUM_CH; k++) begin : g_lane
      assign take[k] = cont[k-1] && (info[k].kind == KIND_SIMPLE);
      assign cont[k] = take[k];
   end

   always_comb begin
      cnt = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         cnt = cnt + CNT_W'(take[k]);
      end
   end

endmodule

// File: rtl/dsteer_seq_gate.sv
module dsteer_seq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_i,
   input  logic launch_i,
   input  logic done_i,
   output logic busy_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
      end else if (flush_i || done_i) begin
         busy_o <= 1'b0;
      end else if (launch_i) begin
         busy_o <= 1'b1;
      end
   end

endmodule

// File: rtl/dsteer_top.sv
module dsteer_top
   import dsteer_pkg::*;
#(
   parameter int NUM_CH    = 3,
   parameter int UOP_W     = 4,
   parameter int LEN_W     = 4,
   parameter int WIDE_UOPS = 4,
   parameter int FAST_LEN  = 7,
   localparam int CNT_W    = $clog2(NUM_CH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         win_vld,
   input  logic [NUM_CH*UOP_W-1:0]   win_uops,
   input  logic [NUM_CH*LEN_W-1:0]   win_len,
   input  logic                      stall_i,
   input  logic                      flush_i,
   input  logic                      ucode_done_i,
   output logic [CNT_W-1:0]          take_cnt,
   output logic [NUM_CH-1:0]         ch_vld,
   output logic [NUM_CH*UOP_W-1:0]   ch_uops,
   output logic [NUM_CH*LEN_W-1:0]   ch_len,
   output logic                      ucode_busy_o
);

   // elaboration-time parameter checks
   if (NUM_CH < 1) begin : g_bad_ch
      $error("dsteer_top: NUM_CH must be at least 1");
   end
   if (WIDE_UOPS < 1 || WIDE_UOPS >= (1 << UOP_W)) begin : g_bad_wide
      $error("dsteer_top: WIDE_UOPS must fit in UOP_W");
   end
   if (FAST_LEN < 1 || FAST_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("dsteer_top: FAST_LEN must fit in LEN_W");
   end

   slot_info_t [NUM_CH-1:0] info;
   logic [NUM_CH-1:0]       take;
   logic [CNT_W-1:0]        cnt;
   logic                    solo;
   logic                    open_w;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_cls
      dsteer_classify #(
         .UOP_W    (UOP_W),
         .LEN_W    (LEN_W),
         .WIDE_UOPS(WIDE_UOPS),
         .FAST_LEN (FAST_LEN)
      ) u_cls (
         .vld (win_vld[k]),
         .uops(win_uops[k*UOP_W +: UOP_W]),
         .len (win_len[k*LEN_W +: LEN_W]),
         .info(info[k])
      );
   end

   assign open_w = !ucode_busy_o && !stall_i && !flush_i;

   dsteer_grouper #(
      .NUM_CH(NUM_CH),
      .CNT_W (CNT_W)
   ) u_grp (
      .open_i(open_w),
      .info  (info),
      .take  (take),
      .cnt   (cnt),
      .solo  (solo)
   );

   dsteer_seq_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_i),
      .launch_i(solo),
      .done_i  (ucode_done_i),
      .busy_o  (ucode_busy_o)
   );

   assign take_cnt = cnt;

   logic [NUM_CH*UOP_W-1:0] nxt_uops;
   logic [NUM_CH*LEN_W-1:0] nxt_len;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_mask
      assign nxt_uops[k*UOP_W +: UOP_W] = take[k] ? win_uops[k*UOP_W +: UOP_W] : '0;
      assign nxt_len[k*LEN_W +: LEN_W]  = take[k] ? win_len[k*LEN_W +: LEN_W]  : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         ch_vld  <= '0;
         ch_uops <= '0;
         ch_len  <= '0;
      end else if (!stall_i) begin
         ch_vld  <= take;
         ch_uops <= nxt_uops;
         ch_len  <= nxt_len;
      end
   end

endmodule

// File: rtl/dsteer_chk.sv
module dsteer_chk #(
   parameter int NUM_CH    = 3,
   parameter int UOP_W     = 4,
   parameter int LEN_W     = 4,
   parameter int WIDE_UOPS = 4,
   parameter int FAST_LEN  = 7,
   localparam int CNT_W    = $clog2(NUM_CH + 1)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    stall_i,
   input logic                    flush_i,
   input logic [CNT_W-1:0]        take_cnt,
   input logic [NUM_CH-1:0]       ch_vld,
   input logic [NUM_CH*UOP_W-1:0] ch_uops,
   input logic [NUM_CH*LEN_W-1:0] ch_len,
   input logic                    ucode_busy_o
);

   AST_LANES_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      ((ch_vld & (ch_vld + 1'b1)) == '0));  // R6

   AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      ucode_busy_o |-> (take_cnt == '0));  // R5

   AST_SOLO_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_vld[0] && (ch_uops[UOP_W-1:0] > UOP_W'(WIDE_UOPS))) |-> ($countones(ch_vld) == 1));  // R5

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i && !flush_i) |=> ($stable(ch_vld) && $stable(ch_uops) && $stable(ch_len)));  // R7

   AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |-> (take_cnt == '0));  // R7

   AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> ((ch_vld == '0) && !ucode_busy_o));  // R8

   AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && !flush_i) |=> ($countones(ch_vld) == int'($past(take_cnt))));  // R9

   for (genvar k = 1; k < NUM_CH; k++) begin : g_side
      AST_SIDE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         ch_vld[k] |-> (ch_uops[k*UOP_W +: UOP_W] <= UOP_W'(1)));  // R3
      AST_SIDE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
         ch_vld[k] |-> (ch_len[k*LEN_W +: LEN_W] <= LEN_W'(FAST_LEN)));  // R4
   end

endmodule

bind dsteer_top dsteer_chk #(
   .NUM_CH   (NUM_CH),
   .UOP_W    (UOP_W),
   .LEN_W    (LEN_W),
   .WIDE_UOPS(WIDE_UOPS),
   .FAST_LEN (FAST_LEN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stall_i     (stall_i),
   .flush_i     (flush_i),
   .take_cnt    (take_cnt),
   .ch_vld      (ch_vld),
   .ch_uops     (ch_uops),
   .ch_len      (ch_len),
   .ucode_busy_o(ucode_busy_o)
);

// File: tb/sim_dsteer_top.sv
module sim_dsteer_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 3;
   localparam int UW  = 4;
   localparam int LW  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  win_vld = '0;
   logic [NCH*UW-1:0] win_uops = '0;
   logic [NCH*LW-1:0] win_len = '0;
   logic            stall_i = 1'b0;
   logic            flush_i = 1'b0;
   logic            ucode_done_i = 1'b0;
   logic [1:0]      take_cnt;
   logic [NCH-1:0]  ch_vld;
   logic [NCH*UW-1:0] ch_uops;
   logic [NCH*LW-1:0] ch_len;
   logic            ucode_busy_o;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit ended = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsteer_top u0 (
      .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_uops(win_uops),
      .win_len(win_len), .stall_i(stall_i), .flush_i(flush_i),
      .ucode_done_i(ucode_done_i), .take_cnt(take_cnt), .ch_vld(ch_vld),
      .ch_uops(ch_uops), .ch_len(ch_len), .ucode_busy_o(ucode_busy_o)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
         finish_run();
      end
   end

   // entry classes: 0 empty, 1 one-uop 3B, 2 two-uop 3B, 3 four-uop 6B,
   // 4 five-uop 5B, 5 one-uop 8B, 6 one-uop 7B
   function automatic int c_uops(input int c);
      case (c)
         1: return 1; 2: return 2; 3: return 4; 4: return 5;
         5: return 1; 6: return 1; default: return 0;
      endcase
   endfunction
   function automatic int c_len(input int c);
      case (c)
         1: return 3; 2: return 3; 3: return 6; 4: return 5;
         5: return 8; 6: return 7; default: return 0;
      endcase
   endfunction
   function automatic bit c_side_ok(input int c);
      return (c != 0) && c_uops(c) == 1 && c_len(c) <= 7;
   endfunction

   function automatic int exp_count(input int a, input int b, input int c);
      int n = 0;
      if (a != 0) begin
         n = 1;
         if (c_uops(a) <= 4 && c_len(a) <= 7 && c_side_ok(b)) begin
            n = 2;
            if (c_side_ok(c)) n = 3;
         end
      end
      return n;
   endfunction

   task automatic set_win(input int a, input int b, input int c);
      int cl[3];
      cl[0] = a; cl[1] = b; cl[2] = c;
      for (int k = 0; k < NCH; k++) begin
         win_vld[k] = (cl[k] != 0);
         win_uops[k*UW +: UW] = UW'(c_uops(cl[k]));
         win_len[k*LW +: LW]  = LW'(c_len(cl[k]));
      end
   endtask

   task automatic check_lanes(input int a, input int b, input int c, input int n, input string req);
      int cl[3];
      int ev = 0;
      cl[0] = a; cl[1] = b; cl[2] = c;
      for (int k = 0; k < n; k++) ev |= (1 << k);
      check({req, " lanes"}, int'(ch_vld), ev);
      for (int k = 0; k < NCH; k++) begin
         check({req, " uops"}, int'(ch_uops[k*UW +: UW]), (k < n) ? c_uops(cl[k]) : 0);
         check({req, " len"}, int'(ch_len[k*LW +: LW]), (k < n) ? c_len(cl[k]) : 0);
      end
   endtask

   task automatic run_combo(input int a, input int b, input int c);
      int n;
      bit solo;
      n = exp_count(a, b, c);
      solo = (a != 0) && c_uops(a) > 4;
      @(negedge clk);
      set_win(a, b, c);
      #1;
      check("R2 R3 R4 R6 take_cnt", int'(take_cnt), n);
      @(negedge clk);
      check_lanes(a, b, c, n, "R9");
      check("R5 busy", int'(ucode_busy_o), int'(solo));
      if (solo) begin
         #1;
         check("R5 no take while busy", int'(take_cnt), 0);
         @(negedge clk);
         check("R5 no group while busy", int'(ch_vld), 0);
         check("R5 busy held", int'(ucode_busy_o), 1);
         ucode_done_i = 1'b1;
         @(negedge clk);
         ucode_done_i = 1'b0;
         check("R5 busy cleared by done", int'(ucode_busy_o), 0);
      end
      win_vld = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 lanes", int'(ch_vld), 0);
      check("R1 busy", int'(ucode_busy_o), 0);
      rst_n = 1'b1;
      #1;
      check("R1 take_cnt", int'(take_cnt), 0);
      check("R1 uops", int'(ch_uops), 0);
      check("R1 len", int'(ch_len), 0);

      // sweep every class combination over the three slots
      for (int a = 0; a < 7; a++)
         for (int b = 0; b < 7; b++)
            for (int c = 0; c < 7; c++)
               run_combo(a, b, c);

      // R7: stall holds a loaded group and consumes nothing
      @(negedge clk);
      set_win(1, 1, 1);
      @(negedge clk);
      check("R7 group loaded", int'(ch_vld), 7);
      stall_i = 1'b1;
      set_win(3, 0, 0);
      #1;
      check("R7 take during stall", int'(take_cnt), 0);
      @(negedge clk);
      check("R7 lanes held", int'(ch_vld), 7);
      check("R7 len held", int'(ch_len[LW-1:0]), 3);
      stall_i = 1'b0;
      @(negedge clk);
      check("R7 after stall", int'(ch_vld), 1);
      check("R7 after stall uops", int'(ch_uops[UW-1:0]), 4);

      // R8: flush on a loaded group
      flush_i = 1'b1;
      #1;
      check("R8 take during flush", int'(take_cnt), 0);
      @(negedge clk);
      flush_i = 1'b0;
      win_vld = '0;
      check("R8 lanes cleared", int'(ch_vld), 0);

      // R8: flush drops the sequencer wait
      set_win(4, 1, 1);
      @(negedge clk);
      check("R8 busy set", int'(ucode_busy_o), 1);
      win_vld = '0;
      flush_i = 1'b1;
      @(negedge clk);
      flush_i = 1'b0;
      check("R8 busy cleared", int'(ucode_busy_o), 0);
      check("R8 lanes empty", int'(ch_vld), 0);
      set_win(1, 1, 0);
      #1;
      check("R8 accepts after flush", int'(take_cnt), 2);
      @(negedge clk);
      win_vld = '0;
      @(negedge clk);
      finish_run();
   end

endmodule